// File: doc/BRIEF.md
# Standby and CPU Power Bring-Up Sequencer

This block is a hardware state machine that brings up an always-on standby power domain and then a CPU subsystem after a hardware reset. It walks a fixed list of release steps. Each step drives one registered control output high. It then waits for that step's acknowledge input, and then waits through a settle interval before the next step begins. The analog power switches, isolation cells, clock gates and the standby arbiter lie outside the block. The block sees them only through their acknowledge lines.

Three steps act on the standby arbiter: clock enable, reset release and a one-cycle configuration strobe. These steps run only when the chip comes back from its code-persistent low-power mode, which the `persist_mode` input signals. In every other case the sequencer jumps from the domain reset release straight to the CPU SRAM step. When the CPU reset has been acknowledged, the block raises a sticky done flag and presents the fixed CPU reset vector 0xFF80_0000. If an acknowledge fails to arrive within the timeout, the block sets a sticky error flag and freezes where it stands.

Top module: `pwr_bringup_seq`

## Requirements
- R1: While `rst` is high (synchronous, active high), and in the cycle after it, all release outputs, `arb_cfg_stb`, `seq_done` and `seq_err` are 0 and `boot_addr` is 0. A reset applied partway through the sequence returns everything to this state.
- R2: Outputs rise in this fixed order: `dom_pwr_en`, `dom_iso_rel`, `dom_rst_rel`, [`arb_clk_en`, `arb_rst_rel`, `arb_cfg_stb`], `cpu_sram_on`, `cpu_clk_en`, `cpu_rst_rel`. `dom_pwr_en` rises on the first clock edge after reset.
- R3: `step_ack` bit i acknowledges step i, numbered 0 to 8 in the order of R2. The sequencer does not leave a step until that bit is seen high.
- R4: After an acknowledge is seen, the settle interval lasts max(`settle_len`, MIN_SETTLE) cycles, with MIN_SETTLE = 4. The next output therefore rises settle+2+L edges after the previous one, where L is the acknowledge latency in cycles.
- R5: When `persist_mode` is 1, the arbiter clock enable and arbiter reset release are asserted. After them, `arb_cfg_stb` is high for exactly one cycle. Its acknowledge is `step_ack[5]`.
- R6: When `persist_mode` is 0, `arb_clk_en`, `arb_rst_rel` and `arb_cfg_stb` stay 0, and `cpu_sram_on` follows the settle interval after the domain reset release.
- R7: `seq_done` rises on the edge after `step_ack[8]` is seen and stays high until reset. While it is high, `boot_addr` equals 0xFF80_0000.
- R8: If a step's acknowledge stays low for ACK_TIMEOUT consecutive waiting cycles, `seq_err` rises and stays high, and all outputs hold their values until reset.
- R9: A release output that has risen never falls until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| persist_mode | input | 1 | Wake from code-persistent mode; enables the arbiter steps |
| settle_len | input | SETTLE_W | Requested settle cycles between steps (floored at MIN_SETTLE) |
| step_ack | input | 9 | Per-step acknowledge, bit i for step i |
| dom_pwr_en | output | 1 | Standby domain power enable |
| dom_iso_rel | output | 1 | Standby domain isolation release |
| dom_rst_rel | output | 1 | Standby domain raw reset release |
| arb_clk_en | output | 1 | Arbiter clock enable |
| arb_rst_rel | output | 1 | Arbiter reset release |
| arb_cfg_stb | output | 1 | One-cycle arbiter configuration strobe |
| cpu_sram_on | output | 1 | CPU SRAM power-down release |
| cpu_clk_en | output | 1 | CPU clock enable |
| cpu_rst_rel | output | 1 | CPU reset release |
| boot_addr | output | 32 | CPU fetch address, valid when done |
| seq_done | output | 1 | Sequence complete (sticky) |
| seq_err | output | 1 | Acknowledge timeout (sticky) |

## Verification
The assertions check on every cycle the relations that always hold between outputs. They cover the pairwise release ordering, the fact that no release output ever falls, the one-cycle width of the configuration strobe, the stickiness of done and error, the freeze of outputs under error, and the boot address while done is high. Exact cycle counts are left to the bench's reference model, which is compared on every clock. These include the settle length with its floor, the latency from acknowledge to next step, the point at which the timeout fires, and the path that skips the arbiter steps. Scenarios with different acknowledge latencies, settle settings, persistent-mode values, a withheld acknowledge and a reset applied partway through the sequence exercise these counts.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam int NSTEP  = 9;
  localparam int STEP_W = 4;

  localparam logic [STEP_W-1:0] ST_PWR  = 4'd0;
  localparam logic [STEP_W-1:0] ST_ISO  = 4'd1;
  localparam logic [STEP_W-1:0] ST_DRST = 4'd2;
  localparam logic [STEP_W-1:0] ST_ACLK = 4'd3;
  localparam logic [STEP_W-1:0] ST_ARST = 4'd4;
  localparam logic [STEP_W-1:0] ST_ACFG = 4'd5;
  localparam logic [STEP_W-1:0] ST_SRAM = 4'd6;
  localparam logic [STEP_W-1:0] ST_CCLK = 4'd7;
  localparam logic [STEP_W-1:0] ST_CRST = 4'd8;

  typedef enum logic [2:0] {
    PH_START  = 3'd0,
    PH_WAIT   = 3'd1,
    PH_SETTLE = 3'd2,
    PH_DONE   = 3'd3,
    PH_ERR    = 3'd4
  } phase_t;
endpackage

// File: rtl/pbs_timer.sv
module pbs_timer #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_q;

  // Saturating up-counter shared by the ack-wait and settle phases.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (cnt_q != {CW{1'b1}}) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pbs_fsm.sv
module pbs_fsm
  import pbs_pkg::*;
#(
  parameter int SETTLE_W    = 8,
  parameter int CW          = 12,
  parameter int ACK_TIMEOUT = 1024,
  parameter int MIN_SETTLE  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                persist,
  input  logic [SETTLE_W-1:0] settle_len,
  input  logic [NSTEP-1:0]    ack,
  input  logic [CW-1:0]       cnt,
  output logic                tmr_clr,
  output logic [NSTEP-1:0]    rel,
  output logic                done,
  output logic                err
);
  localparam logic [CW-1:0]     TMO_LAST = CW'(ACK_TIMEOUT - 1);
  localparam logic [STEP_W-1:0] LAST     = STEP_W'(NSTEP - 1);

  phase_t             phase_q, phase_d;
  logic [STEP_W-1:0]  step_q, step_d;
  logic [NSTEP-1:0]   rel_q;
  logic               done_q, err_q;
  logic [CW-1:0]      settle_eff, settle_last;

  // Requested settle length floored at MIN_SETTLE.
  assign settle_eff  = (CW'(settle_len) < CW'(MIN_SETTLE)) ? CW'(MIN_SETTLE)
                                                           : CW'(settle_len);
  assign settle_last = settle_eff - CW'(1);

  always_comb begin
    phase_d = phase_q;
    step_d  = step_q;
    tmr_clr = 1'b0;
    unique case (phase_q)
      PH_START: begin
        phase_d = PH_WAIT;
        tmr_clr = 1'b1;
      end
      PH_WAIT: begin
        if (ack[step_q]) begin
          if (step_q == LAST) begin
            phase_d = PH_DONE;
          end else begin
            phase_d = PH_SETTLE;
            tmr_clr = 1'b1;
          end
        end else if (cnt == TMO_LAST) begin
          phase_d = PH_ERR;
        end
      end
      PH_SETTLE: begin
        if (cnt == settle_last) begin
          phase_d = PH_START;
          if (step_q == ST_DRST && !persist) step_d = ST_SRAM;
          else                               step_d = step_q + STEP_W'(1);
        end
      end
      default: begin
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_START;
      step_q  <= ST_PWR;
      rel_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      step_q  <= step_d;
      if (phase_q == PH_START) rel_q[step_q] <= 1'b1;
      if (phase_d == PH_DONE)  done_q <= 1'b1;
      if (phase_d == PH_ERR)   err_q  <= 1'b1;
    end
  end

  assign rel  = rel_q;
  assign done = done_q;
  assign err  = err_q;
endmodule

// File: rtl/pwr_bringup_seq.sv
module pwr_bringup_seq
  import pbs_pkg::*;
#(
  parameter int          SETTLE_W    = 8,
  parameter int          ACK_TIMEOUT = 1024,
  parameter int          MIN_SETTLE  = 4,
  parameter logic [31:0] RESET_VEC   = 32'hFF80_0000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                persist_mode,
  input  logic [SETTLE_W-1:0] settle_len,
  input  logic [NSTEP-1:0]    step_ack,
  output logic                dom_pwr_en,
  output logic                dom_iso_rel,
  output logic                dom_rst_rel,
  output logic                arb_clk_en,
  output logic                arb_rst_rel,
  output logic                arb_cfg_stb,
  output logic                cpu_sram_on,
  output logic                cpu_clk_en,
  output logic                cpu_rst_rel,
  output logic [31:0]         boot_addr,
  output logic                seq_done,
  output logic                seq_err
);
  localparam int TMO_W = $clog2(ACK_TIMEOUT + 1);
  localparam int CW    = ((TMO_W > SETTLE_W) ? TMO_W : SETTLE_W) + 1;

  logic [CW-1:0]    cnt;
  logic             tmr_clr;
  logic [NSTEP-1:0] rel;
  logic             done, err;
  logic             cfg_seen_q;

  pbs_timer #(.CW(CW)) u_timer (
    .clk (clk),
    .rst (rst),
    .clr (tmr_clr),
    .cnt (cnt)
  );

  pbs_fsm #(
    .SETTLE_W    (SETTLE_W),
    .CW          (CW),
    .ACK_TIMEOUT (ACK_TIMEOUT),
    .MIN_SETTLE  (MIN_SETTLE)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .persist    (persist_mode),
    .settle_len (settle_len),
    .ack        (step_ack),
    .cnt        (cnt),
    .tmr_clr    (tmr_clr),
    .rel        (rel),
    .done       (done),
    .err        (err)
  );

  // The configuration step is a level internally; present its first cycle only.
  always_ff @(posedge clk) begin
    if (rst) cfg_seen_q <= 1'b0;
    else     cfg_seen_q <= rel[ST_ACFG];
  end

  assign dom_pwr_en  = rel[ST_PWR];
  assign dom_iso_rel = rel[ST_ISO];
  assign dom_rst_rel = rel[ST_DRST];
  assign arb_clk_en  = rel[ST_ACLK];
  assign arb_rst_rel = rel[ST_ARST];
  assign arb_cfg_stb = rel[ST_ACFG] & ~cfg_seen_q;
  assign cpu_sram_on = rel[ST_SRAM];
  assign cpu_clk_en  = rel[ST_CCLK];
  assign cpu_rst_rel = rel[ST_CRST];
  assign boot_addr   = done ? RESET_VEC : 32'h0;
  assign seq_done    = done;
  assign seq_err     = err;
endmodule

// File: rtl/pbs_checker.sv
module pbs_checker #(
  parameter logic [31:0] RESET_VEC = 32'hFF80_0000
) (
  input logic        clk,
  input logic        rst,
  input logic        dom_pwr_en,
  input logic        dom_iso_rel,
  input logic        dom_rst_rel,
  input logic        arb_clk_en,
  input logic        arb_rst_rel,
  input logic        arb_cfg_stb,
  input logic        cpu_sram_on,
  input logic        cpu_clk_en,
  input logic        cpu_rst_rel,
  input logic [31:0] boot_addr,
  input logic        seq_done,
  input logic        seq_err
);
  logic [7:0] lvl;
  assign lvl = {cpu_rst_rel, cpu_clk_en, cpu_sram_on, arb_rst_rel,
                arb_clk_en, dom_rst_rel, dom_iso_rel, dom_pwr_en};

  a_r2_iso_after_pwr: assert property (@(posedge clk) disable iff (rst)
    dom_iso_rel |-> dom_pwr_en);
  a_r2_drst_after_iso: assert property (@(posedge clk) disable iff (rst)
    dom_rst_rel |-> dom_iso_rel);
  a_r2_sram_after_drst: assert property (@(posedge clk) disable iff (rst)
    cpu_sram_on |-> dom_rst_rel);
  a_r2_cpu_rst_last: assert property (@(posedge clk) disable iff (rst)
    cpu_rst_rel |-> (cpu_clk_en && cpu_sram_on));
  a_r5_stb_after_arb: assert property (@(posedge clk) disable iff (rst)
    arb_cfg_stb |-> (arb_clk_en && arb_rst_rel && !cpu_sram_on));
  a_r5_stb_one_cycle: assert property (@(posedge clk) disable iff (rst)
    arb_cfg_stb |=> !arb_cfg_stb);
  a_r6_arb_rst_needs_clk: assert property (@(posedge clk) disable iff (rst)
    arb_rst_rel |-> arb_clk_en);
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> seq_done);
  a_r7_boot_vector: assert property (@(posedge clk) disable iff (rst)
    seq_done |-> (boot_addr == RESET_VEC && cpu_rst_rel));
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    seq_err |=> seq_err);
  a_r8_err_freeze: assert property (@(posedge clk) disable iff (rst)
    seq_err |=> $stable(lvl));
  a_r9_no_fall: assert property (@(posedge clk) disable iff (rst)
    (($past(lvl) & ~lvl) == 8'h00));
endmodule

bind pwr_bringup_seq pbs_checker #(.RESET_VEC(RESET_VEC)) u_pbs_chk (
  .clk         (clk),
  .rst         (rst),
  .dom_pwr_en  (dom_pwr_en),
  .dom_iso_rel (dom_iso_rel),
  .dom_rst_rel (dom_rst_rel),
  .arb_clk_en  (arb_clk_en),
  .arb_rst_rel (arb_rst_rel),
  .arb_cfg_stb (arb_cfg_stb),
  .cpu_sram_on (cpu_sram_on),
  .cpu_clk_en  (cpu_clk_en),
  .cpu_rst_rel (cpu_rst_rel),
  .boot_addr   (boot_addr),
  .seq_done    (seq_done),
  .seq_err     (seq_err)
);

// File: tb/tb_pwr_bringup_seq.sv
module tb_pwr_bringup_seq;
  localparam int TMO = 40;
  localparam int NS  = 9;
  localparam logic [31:0] VEC = 32'hFF80_0000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1;
  logic          persist_mode = 1'b0;
  logic [7:0]    settle_len = 8'd0;
  logic [NS-1:0] step_ack = '0;
  logic dom_pwr_en, dom_iso_rel, dom_rst_rel, arb_clk_en, arb_rst_rel;
  logic arb_cfg_stb, cpu_sram_on, cpu_clk_en, cpu_rst_rel, seq_done, seq_err;
  logic [31:0] boot_addr;

  pwr_bringup_seq #(.ACK_TIMEOUT(TMO)) dut (
    .clk(clk), .rst(rst), .persist_mode(persist_mode), .settle_len(settle_len),
    .step_ack(step_ack), .dom_pwr_en(dom_pwr_en), .dom_iso_rel(dom_iso_rel),
    .dom_rst_rel(dom_rst_rel), .arb_clk_en(arb_clk_en), .arb_rst_rel(arb_rst_rel),
    .arb_cfg_stb(arb_cfg_stb), .cpu_sram_on(cpu_sram_on), .cpu_clk_en(cpu_clk_en),
    .cpu_rst_rel(cpu_rst_rel), .boot_addr(boot_addr), .seq_done(seq_done),
    .seq_err(seq_err)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Acknowledge responder: step i acks lat[i] cycles after its request is seen.
  int   lat [NS];
  int   acnt[NS];
  logic cfg_req;
  logic [NS-1:0] req_vec;
  assign req_vec = {cpu_rst_rel, cpu_clk_en, cpu_sram_on, cfg_req, arb_rst_rel,
                    arb_clk_en, dom_rst_rel, dom_iso_rel, dom_pwr_en};

  always @(negedge clk) begin
    if (rst) begin
      cfg_req  <= 1'b0;
      step_ack <= '0;
      for (int i = 0; i < NS; i++) acnt[i] = 0;
    end else begin
      if (arb_cfg_stb) cfg_req <= 1'b1;
      for (int i = 0; i < NS; i++) begin
        if (req_vec[i] || (i == 5 && arb_cfg_stb)) begin
          if (acnt[i] >= lat[i]) step_ack[i] <= 1'b1;
          else                   acnt[i] = acnt[i] + 1;
        end
      end
    end
  end

  // Behavioural reference model, advanced on each rising edge.
  int   m_ph, m_step, waited, left;
  logic [NS-1:0] m_rel;
  logic m_stb, m_done, m_err, started;
  initial begin
    m_ph = 0; m_step = 0; waited = 0; left = 0;
    m_rel = '0; m_stb = 0; m_done = 0; m_err = 0; started = 0;
  end

  always @(posedge clk) begin
    int seff;
    started = 1'b1;
    seff = (settle_len < 8'd4) ? 4 : int'(settle_len);
    m_stb = 1'b0;
    if (rst) begin
      m_ph = 0; m_step = 0; m_rel = '0; m_done = 0; m_err = 0;
    end else begin
      case (m_ph)
        0: begin
          m_rel[m_step] = 1'b1;
          if (m_step == 5) m_stb = 1'b1;
          m_ph = 1; waited = 0;
        end
        1: begin
          if (step_ack[m_step]) begin
            if (m_step == 8) begin m_ph = 3; m_done = 1'b1; end
            else begin m_ph = 2; left = seff; end
          end else begin
            waited++;
            if (waited == TMO) begin m_ph = 4; m_err = 1'b1; end
          end
        end
        2: begin
          left--;
          if (left == 0) begin
            m_ph = 0;
            m_step = (m_step == 2 && !persist_mode) ? 6 : m_step + 1;
          end
        end
        default: ;
      endcase
    end
  end

  // Per-cycle comparison and event monitors, on the falling edge.
  int cyc = 0, t_pwr = -1, t_iso = -1, stb_cnt = 0;
  always @(negedge clk) begin
    logic [NS-1:0] dv;
    cyc++;
    if (started) begin
      dv = {cpu_rst_rel, cpu_clk_en, cpu_sram_on, 1'b0, arb_rst_rel,
            arb_clk_en, dom_rst_rel, dom_iso_rel, dom_pwr_en};
      chk(dv == (m_rel & 9'h1DF), "R2", "release vector", dv, m_rel & 9'h1DF);
      chk(arb_cfg_stb == m_stb, "R5", "cfg strobe", arb_cfg_stb, m_stb);
      chk(seq_done == m_done, "R7", "done", seq_done, m_done);
      chk(boot_addr == (m_done ? VEC : 32'h0), "R7", "boot_addr", boot_addr,
          m_done ? VEC : 32'h0);
      chk(seq_err == m_err, "R8", "err", seq_err, m_err);
    end
    if (!rst) begin
      if (dom_pwr_en && t_pwr < 0)  t_pwr = cyc;
      if (dom_iso_rel && t_iso < 0) t_iso = cyc;
      if (arb_cfg_stb) stb_cnt++;
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic do_reset(input int n);
    @(negedge clk);
    rst = 1'b1;
    repeat (n) @(negedge clk);
    t_pwr = -1; t_iso = -1; stb_cnt = 0;
    rst = 1'b0;
  endtask

  task automatic run_until_end();
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (seq_done || seq_err) break;
    end
  endtask

  task automatic chk_all_zero(input string what);
    logic [11:0] v;
    v = {dom_pwr_en, dom_iso_rel, dom_rst_rel, arb_clk_en, arb_rst_rel,
         arb_cfg_stb, cpu_sram_on, cpu_clk_en, cpu_rst_rel, seq_done, seq_err,
         |boot_addr};
    chk(v == 12'h0, "R1", what, v, 0);
  endtask

  initial begin
    logic [7:0] snap;
    // Scenario A: persistent wake, settle floored, mixed latencies.
    persist_mode = 1'b1; settle_len = 8'd0;
    lat = '{0, 1, 2, 3, 0, 1, 5, 2, 0};
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk_all_zero("outputs during reset");
    do_reset(2);
    chk_all_zero("outputs right after reset release");
    run_until_end();
    chk(seq_done == 1'b1, "R7", "done after full run", seq_done, 1);
    chk(boot_addr == VEC, "R7", "reset vector", boot_addr, VEC);
    chk({cpu_rst_rel, cpu_clk_en, cpu_sram_on, arb_rst_rel, arb_clk_en,
         dom_rst_rel, dom_iso_rel, dom_pwr_en} == 8'hFF, "R9", "all released",
        {cpu_rst_rel, cpu_clk_en, cpu_sram_on}, 7);
    chk(stb_cnt == 1, "R5", "single cfg strobe", stb_cnt, 1);
    chk(t_iso - t_pwr == 6, "R4", "floored settle spacing", t_iso - t_pwr, 6);
    repeat (6) @(negedge clk);
    chk(seq_done == 1'b1, "R7", "done sticky", seq_done, 1);

    // Scenario B: no persistent wake, arbiter steps skipped.
    persist_mode = 1'b0; settle_len = 8'd7;
    lat = '{2, 0, 1, 0, 0, 0, 1, 3, 2};
    do_reset(2);
    run_until_end();
    chk(seq_done == 1'b1, "R6", "done with skip", seq_done, 1);
    chk({arb_clk_en, arb_rst_rel} == 2'b00, "R6", "arbiter outputs low",
        {arb_clk_en, arb_rst_rel}, 0);
    chk(stb_cnt == 0, "R6", "no cfg strobe", stb_cnt, 0);
    chk(t_iso - t_pwr == 11, "R4", "settle 7 plus latency 2", t_iso - t_pwr, 11);

    // Scenario C: SRAM acknowledge withheld -> timeout.
    persist_mode = 1'b1; settle_len = 8'd5;
    lat = '{0, 0, 0, 0, 0, 0, 100000, 0, 0};
    do_reset(2);
    run_until_end();
    chk(seq_err == 1'b1, "R8", "timeout error", seq_err, 1);
    chk(seq_done == 1'b0, "R8", "no done on error", seq_done, 0);
    chk(cpu_sram_on == 1'b1, "R3", "sram step issued", cpu_sram_on, 1);
    chk(cpu_clk_en == 1'b0, "R3", "no advance without ack", cpu_clk_en, 0);
    chk(t_iso - t_pwr == 7, "R4", "settle 5 spacing", t_iso - t_pwr, 7);
    snap = {cpu_rst_rel, cpu_clk_en, cpu_sram_on, arb_rst_rel, arb_clk_en,
            dom_rst_rel, dom_iso_rel, dom_pwr_en};
    repeat (10) @(negedge clk);
    chk({cpu_rst_rel, cpu_clk_en, cpu_sram_on, arb_rst_rel, arb_clk_en,
         dom_rst_rel, dom_iso_rel, dom_pwr_en} == snap, "R8", "frozen outputs",
        {cpu_clk_en, cpu_sram_on}, snap[6:5]);
    chk(seq_err == 1'b1, "R8", "error sticky", seq_err, 1);

    // Scenario D: reset partway through.
    settle_len = 8'd4;
    lat = '{1, 1, 1, 1, 1, 1, 1, 1, 1};
    do_reset(2);
    repeat (20) @(negedge clk);
    chk(dom_pwr_en == 1'b1, "R2", "sequence under way", dom_pwr_en, 1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk_all_zero("mid-run reset");
    rst = 1'b0;
    run_until_end();
    chk(seq_done == 1'b1, "R7", "done after re-run", seq_done, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule